// File: doc/BRIEF.md
# Eight-Lane Block-Memory Dot-Product Engine

This block computes eight independent signed dot products from two external block memories that are read side by side. One memory holds feature bytes and the other holds weight bytes. Both have a 64-bit read port with one cycle of read latency. The engine presents a single read address that both memories share. It splits every returned word pair into eight byte lanes and multiplies lane k of the feature word by lane k of the weight word. Each product is added into its own 32-bit accumulator.

A host starts the engine by writing a 32-bit control word. The top bit of that word requests a run, and the low bits give how many input bytes to process. A control state machine latches the count and clears the accumulators. It then streams one word pair per clock and raises a done flag. The flag and the eight sums stay put until the next start. The bus slave that holds the control word, and the transfer engine that fills the memories, sit outside this block.

Top module: `dpe_engine`

## Requirements
- R1: A run starts only when bit 31 of `ctrl_word` is seen going from 0 to 1 while the engine is idle or done. A flag that stays at 1 does not start a second run. A 0-to-1 edge that arrives while a run is in progress is ignored.
- R2: The byte count is `ctrl_word[CNT_W-1:0]` (bits 15:0 by default), latched on the start edge. Bits 30 down to CNT_W are ignored, and so are changes to the count while a run is in progress.
- R3: For a count C, the engine reads W = ceil(C/8) words. It asserts `mem_rd_en` exactly W times, on consecutive cycles, with `mem_rd_addr` going 0, 1, ..., W-1. It never reads while `done` is high.
- R4: Byte k (bits 8k+7:8k) of each feature word is multiplied by byte k of the weight word at the same address. Both bytes are signed two's complement. The product is sign-extended and added into lane k's 32-bit sum, which appears on `results[32k+31:32k]`.
- R5: In a final partial word (C mod 8 = m, with m not 0), lanes m through 7 add nothing.
- R6: Every run starts from zero sums, so values from an earlier run never leak into the next one.
- R7: Let E0 be the clock edge that samples the start. `done` is low after edges E0 to E0+W and is high after edge E0+W+1.
- R8: Once high, `done` and all eight sums hold their values until the next start edge. That edge clears `done` one edge later.
- R9: A count of 0 makes no memory read. It gives `done` after edge E0+1, and all eight sums equal 0.
- R10: After reset, `done` is 0, `mem_rd_en` is 0 and every sum is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctrl_word | input | 32 | Control word: bit 31 requests a run, bits CNT_W-1:0 give the byte count |
| mem_rd_en | output | 1 | Read enable for both memories |
| mem_rd_addr | output | CNT_W-3 | Word address shared by both memories |
| feat_rdata | input | 64 | Feature word, valid one cycle after the read |
| wt_rdata | input | 64 | Weight word, valid one cycle after the read |
| done | output | 1 | High when the run has finished, until the next start |
| results | output | 256 | Eight 32-bit signed sums; lane k at bits 32k+31:32k |

## Verification
The bound checker watches the read stream on every cycle. It checks that each burst of reads starts at address 0 and steps by one, and that no read happens while `done` is high. It also checks that `done` and the sums stay frozen until a start edge, and that a start edge in the done state clears `done`. The signed arithmetic, the masking of a partial last word, the exact latency and the number of reads can only be shown by the bench's scenarios. The same holds for ignoring held or mid-run flag edges and the upper control bits. The bench sweeps every byte count from 0 to 40 and adds extreme-value and full-memory runs, with the expected sums worked out in the bench.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_FETCH = 2'd2,
    ST_DONE  = 2'd3
  } dpe_state_e;

  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned RUN_BIT = 31;
endpackage

// File: rtl/dpe_rst_sync.sv
module dpe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dpe_ctrl.sv
module dpe_ctrl
  import dpe_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned LB    = $clog2(LANES),
  localparam int unsigned ADDRW = CNT_W - LB,
  localparam int unsigned WORDW = CNT_W - LB + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_flag,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic             rd_en,
  output logic [ADDRW-1:0] rd_addr,
  output logic             acc_clr,
  output logic             acc_en,
  output logic [LANES-1:0] lane_keep,
  output logic             done
);
  dpe_state_e       state_q, state_d;
  logic             run_q;
  logic [WORDW-1:0] nwords_q, nwords_d;
  logic [LB-1:0]    tail_q;
  logic [WORDW-1:0] ptr_q, ptr_d;
  logic             vld_q, last_q;
  logic [LANES-1:0] mask_q, mask_d;
  logic             rise, start, issue_last;
  logic [CNT_W:0]   round_up;

  assign rise  = run_flag & ~run_q;
  assign start = rise & ((state_q == ST_IDLE) | (state_q == ST_DONE));

  // word count = ceil(bytes / LANES)
  assign round_up = {1'b0, byte_cnt} + (CNT_W+1)'(LANES - 1);
  assign nwords_d = round_up[CNT_W:LB];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_CLEAR;
      ST_CLEAR: state_d = (nwords_q == '0) ? ST_DONE : ST_FETCH;
      ST_FETCH: if (vld_q && last_q) state_d = ST_DONE;
      ST_DONE:  if (start) state_d = ST_CLEAR;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign rd_en      = ((state_q == ST_CLEAR) | (state_q == ST_FETCH)) & (ptr_q < nwords_q);
  assign rd_addr    = ptr_q[ADDRW-1:0];
  assign issue_last = (ptr_q == nwords_q - 1'b1);

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      mask_d[k] = !(issue_last && (tail_q != '0)) || (k < int'(tail_q));
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (start)      ptr_d = '0;
    else if (rd_en) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= 1'b0;
      ptr_q   <= '0;
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_flag;
      ptr_q   <= ptr_d;
      vld_q   <= rd_en;
      last_q  <= rd_en & issue_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nwords_q <= '0;
      tail_q   <= '0;
    end else if (start) begin
      nwords_q <= nwords_d;
      tail_q   <= byte_cnt[LB-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (rd_en) mask_q <= mask_d;
  end

  assign acc_clr   = (state_q == ST_CLEAR);
  assign acc_en    = vld_q;
  assign lane_keep = mask_q;
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/dpe_mac_lane.sv
module dpe_mac_lane #(
  parameter int unsigned OPW  = 8,
  parameter int unsigned ACCW = 32,
  localparam int unsigned PW  = 2 * OPW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic            keep,
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  output logic [ACCW-1:0] acc
);
  logic signed [PW-1:0] prod;
  logic [ACCW-1:0]      prod_ext;
  logic [ACCW-1:0]      acc_q, acc_d;
  logic                 acc_we;

  assign prod     = $signed(a) * $signed(b);
  assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};
  assign acc_we   = clr | (en & keep);

  always_comb begin
    if (clr) acc_d = '0;
    else     acc_d = acc_q + prod_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_we) acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/dpe_engine.sv
module dpe_engine
  import dpe_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned OPW   = 8,
  parameter int unsigned ACCW  = 32,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned ADDRW = CNT_W - $clog2(LANES),
  localparam int unsigned DW    = LANES * OPW,
  localparam int unsigned RW    = LANES * ACCW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ctrl_word,
  output logic              mem_rd_en,
  output logic [ADDRW-1:0]  mem_rd_addr,
  input  logic [DW-1:0]     feat_rdata,
  input  logic [DW-1:0]     wt_rdata,
  output logic              done,
  output logic [RW-1:0]     results
);
  logic             rst_n_s;
  logic             acc_clr, acc_en;
  logic [LANES-1:0] lane_keep;
  logic             unused_ctrl_bits;

  assign unused_ctrl_bits = ^ctrl_word[RUN_BIT-1:CNT_W];

  dpe_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dpe_ctrl #(.LANES(LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_flag  (ctrl_word[RUN_BIT]),
    .byte_cnt  (ctrl_word[CNT_W-1:0]),
    .rd_en     (mem_rd_en),
    .rd_addr   (mem_rd_addr),
    .acc_clr   (acc_clr),
    .acc_en    (acc_en),
    .lane_keep (lane_keep),
    .done      (done)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dpe_mac_lane #(.OPW(OPW), .ACCW(ACCW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n_s),
      .clr   (acc_clr),
      .en    (acc_en),
      .keep  (lane_keep[k]),
      .a     (feat_rdata[k*OPW +: OPW]),
      .b     (wt_rdata[k*OPW +: OPW]),
      .acc   (results[k*ACCW +: ACCW])
    );
  end
endmodule

// File: rtl/dpe_engine_chk.sv
module dpe_engine_chk #(
  parameter int unsigned ADDRW = 13,
  parameter int unsigned RW    = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_flag,
  input logic             mem_rd_en,
  input logic [ADDRW-1:0] mem_rd_addr,
  input logic             done,
  input logic [RW-1:0]    results
);
  logic run_prev_q;
  logic rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_prev_q <= 1'b0;
    else        run_prev_q <= run_flag;
  end

  assign rise = run_flag & ~run_prev_q;

  // R3
  addr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !$past(mem_rd_en)) |-> (mem_rd_addr == '0));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == ADDRW'($past(mem_rd_addr) + 1'b1)));

  // R3
  no_read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd_en);

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rise) |=> (done && $stable(results)));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rise) |=> !done);
endmodule

bind dpe_engine dpe_engine_chk #(.ADDRW(ADDRW), .RW(RW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run_flag    (ctrl_word[31]),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .done        (done),
  .results     (results)
);

// File: tb/dpe_engine_bench.sv
module dpe_engine_bench;
  localparam int MW = 64;

  logic         clk;
  logic         rst_n;
  logic [31:0]  ctrl_word;
  logic         mem_rd_en;
  logic [12:0]  mem_rd_addr;
  logic [63:0]  feat_rdata, wt_rdata;
  logic         done;
  logic [255:0] results;

  logic [63:0] fmem [MW];
  logic [63:0] wmem [MW];
  int nchk = 0;
  int nerr = 0;
  int rd_total = 0;
  int unsigned rng = 32'h1234_5678;

  dpe_engine u_dpe_engine (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .feat_rdata(feat_rdata), .wt_rdata(wt_rdata),
    .done(done), .results(results)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_rd_en) begin
      feat_rdata <= fmem[mem_rd_addr[5:0]];
      wt_rdata   <= wmem[mem_rd_addr[5:0]];
      rd_total   <= rd_total + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic fill(input int mode);
    for (int i = 0; i < MW; i++) begin
      case (mode)
        1: begin fmem[i] = {8{8'h80}}; wmem[i] = {8{8'h80}}; end
        2: begin fmem[i] = {8{8'h80}}; wmem[i] = {8{8'h7F}}; end
        default: begin
          fmem[i] = {next_rng(), next_rng()};
          wmem[i] = {next_rng(), next_rng()};
        end
      endcase
    end
  endtask

  function automatic int expect_sum(input int k, input int cnt);
    int s = 0;
    for (int b = 0; b < cnt; b++) begin
      if ((b % 8) == k)
        s += int'($signed(fmem[b/8][8*k +: 8])) * int'($signed(wmem[b/8][8*k +: 8]));
    end
    return s;
  endfunction

  // cnt: byte count; junk: bits 30:16; glitch: flag edge mid-run; chg: count change mid-run
  task automatic do_run(input int cnt, input logic [14:0] junk, input bit glitch, input bit chg);
    int w, base;
    bit early;
    logic [255:0] snap;
    w = (cnt + 7) / 8;
    early = 1'b0;
    @(negedge clk);
    ctrl_word = {1'b1, junk, 16'(cnt)};
    base = rd_total;
    @(posedge clk);
    for (int i = 0; i <= w; i++) begin
      @(negedge clk);
      if (done) early = 1'b1;
      if (chg && i == 0) ctrl_word[15:0] = 16'(cnt) ^ 16'h0015;
      if (glitch && i == 1) ctrl_word[31] = 1'b0;
      if (glitch && i == 2) ctrl_word[31] = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    chk(!early, "R7", $sformatf("done too early cnt=%0d", cnt), early, 0);
    chk(done, "R7", $sformatf("done at E0+W+1 cnt=%0d", cnt), done, 1);
    if (cnt == 0)
      chk(rd_total == base, "R9", "no reads for zero count", rd_total - base, 0);
    else
      chk(rd_total - base == w, "R3", $sformatf("read count cnt=%0d", cnt), rd_total - base, w);
    for (int k = 0; k < 8; k++) begin
      int e, a;
      e = expect_sum(k, cnt);
      a = int'(results[32*k +: 32]);
      chk(a == e, (cnt % 8 != 0 && k >= cnt % 8) ? "R5" : "R4",
          $sformatf("lane %0d cnt=%0d", k, cnt), a, e);
    end
    snap = results;
    repeat (3) @(negedge clk);
    chk(done && results == snap, "R1", "held flag does not restart, R8 hold",
        done, 1);
    ctrl_word[31] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctrl_word = '0;
    fill(0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10
    chk(!done && !mem_rd_en && results == '0, "R10", "reset state", done, 0);

    // R4 R5 R6 R7 sweep of every count 0..40 with fresh data each time
    for (int c = 0; c <= 40; c++) begin
      fill(0);
      do_run(c, 15'h0, 1'b0, 1'b0);
    end
    // R9 zero count after a nonzero run: sums return to zero (R6)
    fill(1);
    do_run(16, 15'h0, 1'b0, 1'b0);
    do_run(0, 15'h0, 1'b0, 1'b0);
    // R2 upper bits set and count changed mid-run
    fill(0);
    do_run(511, 15'h7ABC, 1'b0, 1'b1);
    // extreme operands, full memory
    fill(1);
    do_run(512, 15'h0, 1'b0, 1'b0);
    // R1 flag edge during the run is ignored
    fill(2);
    do_run(100, 15'h0, 1'b1, 1'b0);
    fill(0);
    do_run(77, 15'h1, 1'b1, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule